// File: doc/BRIEF.md
# Sector Write-Protection Manager

This block guards modifications of a 1-Mbyte serial flash. It holds the write-enable latch, a protection flag for each of the 19 sectors, and a lock flag that freezes those flags. A command decoder in front of it delivers one-cycle strobes for write enable, write disable, protect sector, unprotect sector, write status and program/erase requests. With them it delivers the 24-bit address, the status data byte and two qualifiers that tell whether the address phase was complete and whether chip select rose on a byte boundary. A separate strobe marks the release of chip select.

The block decides whether each request is allowed and updates its own state. For program and erase it raises a one-cycle grant. The sector flags are always visible, and for the sector addressed by `cmd_addr` a readback byte is formed. The sector map is irregular. The lowest fifteen sectors are 64 KB each. The top 64 KB is split into a 16 KB sector, two 8 KB sectors and a 32 KB sector.

All strobes are mutually exclusive, and at most one is high in any cycle. State changes become visible one clock after the strobe. The readback byte follows `cmd_addr` combinationally.

Top module: `wp_sector_mgr`

## Requirements
- R1: Sector index from address bits 19..0: a value of bits 19..16 below 15 selects that sector. Within the top 64 KB, offsets 0x0000–0x3FFF are sector 15, 0x4000–0x5FFF sector 16, 0x6000–0x7FFF sector 17 and 0x8000–0xFFFF sector 18.
- R2: While `wel` is 0, the protect, unprotect, write-status and program/erase strobes change no state and give no grant.
- R3: `wren_stb` sets `wel` and `wrdi_stb` clears it. Every accepted protect, unprotect, write-status or program/erase request clears `wel`.
- R4: A program/erase request with `wel`=1 to an unprotected sector pulses `modify_grant` for one cycle, starting the cycle after the strobe. If the sector is protected, no grant follows and `wel` is cleared.
- R5: An accepted protect strobe sets the flag of the addressed sector, and an accepted unprotect strobe clears it. No other flag changes.
- R6: A protect or unprotect with `addr_complete`=0 or `byte_aligned`=0 leaves all flags unchanged and clears `wel`.
- R7: While `lock_bit`=1, protect and unprotect change no flag and `wel` stays 1 until the next `cs_release` strobe, after which it is 0. No write-status data changes any flag.
- R8: An accepted write status with `lock_bit`=0 clears all flags when `sr_data[5:2]` is 4'b0000 and sets all flags when it is 4'b1111. Any other value leaves the flags unchanged.
- R9: An accepted write status with `sr_data[7]`=1 sets `lock_bit`. With `sr_data[7]`=0 it clears `lock_bit` only while `hw_wp`=0, so writing 0x0F while `hw_wp`=1 keeps the lock.
- R10: After reset `wel`=0, `lock_bit`=0, `modify_grant`=0 and all 19 flags are 1.
- R11: `qry_byte` is 0xFF when the sector addressed by `cmd_addr` is protected and 0x00 otherwise.
- R12: Address bits 23..20 do not affect sector selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| prot_stb | input | 1 | Protect-sector command strobe |
| unprot_stb | input | 1 | Unprotect-sector command strobe |
| wrsr_stb | input | 1 | Write-status command strobe |
| modify_stb | input | 1 | Program or erase request strobe |
| cs_release | input | 1 | Chip-select release strobe |
| addr_complete | input | 1 | All three address bytes were received |
| byte_aligned | input | 1 | Chip select released on a byte boundary |
| hw_wp | input | 1 | Hardware write-protect, high = asserted |
| cmd_addr | input | 24 | Command address |
| sr_data | input | 8 | Write-status data byte |
| modify_grant | output | 1 | One-cycle permit for program/erase |
| wel | output | 1 | Write-enable latch |
| lock_bit | output | 1 | Protection-register lock |
| prot_bits | output | 19 | Per-sector protection flags, bit n = sector n |
| qry_byte | output | 8 | Protection readback for the addressed sector |

## Verification
Every state result (`wel`, `lock_bit`, `prot_bits`) and the grant pulse is due exactly one clock after its strobe. The bench drives each strobe on a falling edge and compares on the following falling edge, after one rising edge has registered the update. The grant is therefore seen only in that one window and must be absent one cycle later. `qry_byte` has no register in its path, so it is compared in the same window against the updated flags of the sector selected by the held address.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int ADDR_W    = 24;
  localparam int NUM_SECT  = 19;
  localparam int BIG_SECTS = 15;
  localparam int SECT_W    = $clog2(NUM_SECT);
  localparam int SR_W      = 8;
  localparam int QRY_W     = 8;
endpackage

// File: rtl/wpm_rst_sync.sv
module wpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wpm_sect_dec.sv
module wpm_sect_dec #(
  parameter int SECT_W    = 5,
  parameter int BIG_SECTS = 15
) (
  input  logic [6:0]        addr_hi,   // address bits 19..13
  output logic [SECT_W-1:0] sect_idx
);
  localparam int S_QUARTER = BIG_SECTS;
  localparam int S_EIGHTH0 = BIG_SECTS + 1;
  localparam int S_EIGHTH1 = BIG_SECTS + 2;
  localparam int S_HALF    = BIG_SECTS + 3;

  logic [3:0] blk;
  logic [2:0] sub;

  assign blk = addr_hi[6:3];
  assign sub = addr_hi[2:0];

  always_comb begin
    if (int'(blk) < BIG_SECTS) begin
      sect_idx = SECT_W'(blk);
    end else begin
      unique case (sub)
        3'b000, 3'b001: sect_idx = SECT_W'(S_QUARTER);
        3'b010:         sect_idx = SECT_W'(S_EIGHTH0);
        3'b011:         sect_idx = SECT_W'(S_EIGHTH1);
        default:        sect_idx = SECT_W'(S_HALF);
      endcase
    end
  end
endmodule

// File: rtl/wpm_prot_bank.sv
module wpm_prot_bank #(
  parameter int NUM_SECT = 19,
  parameter int SECT_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_one,
  input  logic                clr_one,
  input  logic                set_all,
  input  logic                clr_all,
  input  logic [SECT_W-1:0]   sect_idx,
  output logic [NUM_SECT-1:0] bits
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_flag
    logic hit, en, d;
    assign hit = (int'(sect_idx) == i);

    always_comb begin
      en = set_all | clr_all | (hit & (set_one | clr_one));
      d  = set_all | (hit & set_one);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bits[i] <= 1'b1;
      else if (en) bits[i] <= d;
    end
  end

  a_r5_single_bank_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_one, clr_one, set_all, clr_all}));

  a_r5_one_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (set_one || clr_one) |=> ($countones(bits ^ $past(bits)) <= 1));
endmodule

// File: rtl/wpm_ctrl.sv
module wpm_ctrl #(
  parameter int SR_W   = 8,
  parameter int GLB_HI = 5,
  parameter int GLB_LO = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wren,
  input  logic            req_wrdi,
  input  logic            req_prot,
  input  logic            req_unprot,
  input  logic            req_wrsr,
  input  logic            req_mod,
  input  logic            cs_rel,
  input  logic            addr_complete,
  input  logic            byte_aligned,
  input  logic            hw_wp,
  input  logic [SR_W-1:0] sr_data,
  input  logic            sect_is_prot,
  output logic            wel,
  output logic            lock,
  output logic            grant,
  output logic            bank_set_one,
  output logic            bank_clr_one,
  output logic            bank_set_all,
  output logic            bank_clr_all
);
  localparam int LOCK_POS = SR_W - 1;
  localparam int GLB_W    = GLB_HI - GLB_LO + 1;

  logic wel_q, wel_d, lock_q, lock_d, pend_q, pend_d, grant_q, grant_d;
  logic [GLB_W-1:0] glb_pat;
  logic sr_unused;

  assign glb_pat   = sr_data[GLB_HI:GLB_LO];
  assign sr_unused = ^{sr_data[LOCK_POS-1:GLB_HI+1], sr_data[GLB_LO-1:0]};

  always_comb begin
    wel_d        = wel_q;
    lock_d       = lock_q;
    pend_d       = pend_q;
    grant_d      = 1'b0;
    bank_set_one = 1'b0;
    bank_clr_one = 1'b0;
    bank_set_all = 1'b0;
    bank_clr_all = 1'b0;

    if (cs_rel) begin
      if (pend_q) wel_d = 1'b0;
      pend_d = 1'b0;
    end

    if (req_wrdi) begin
      wel_d  = 1'b0;
      pend_d = 1'b0;
    end else if (req_wren) begin
      wel_d = 1'b1;
    end else if (req_mod && wel_q) begin
      wel_d   = 1'b0;
      grant_d = !sect_is_prot;
    end else if ((req_prot || req_unprot) && wel_q) begin
      if (!addr_complete || !byte_aligned) begin
        wel_d = 1'b0;
      end else if (lock_q) begin
        pend_d = 1'b1;
      end else begin
        wel_d        = 1'b0;
        bank_set_one = req_prot;
        bank_clr_one = req_unprot;
      end
    end else if (req_wrsr && wel_q) begin
      wel_d = 1'b0;
      if (!lock_q) begin
        bank_clr_all = (glb_pat == '0);
        bank_set_all = (glb_pat == '1);
      end
      if (sr_data[LOCK_POS]) lock_d = 1'b1;
      else if (!hw_wp)       lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      lock_q  <= 1'b0;
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      wel_q   <= wel_d;
      lock_q  <= lock_d;
      pend_q  <= pend_d;
      grant_q <= grant_d;
    end
  end

  assign wel   = wel_q;
  assign lock  = lock_q;
  assign grant = grant_q;

  a_r4_grant_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> !wel_q);

  a_r2_no_grant_without_wel: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> $past(wel_q));

  a_r7_release_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cs_rel && !req_wren) |=> !wel_q);

  a_r9_lock_kept_under_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && hw_wp) |=> lock_q);
endmodule

// File: rtl/wp_sector_mgr.sv
module wp_sector_mgr
  import wpm_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int N_S = NUM_SECT,
  parameter int B_S = BIG_SECTS,
  parameter int D_W = SR_W,
  parameter int Q_W = QRY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wren_stb,
  input  logic           wrdi_stb,
  input  logic           prot_stb,
  input  logic           unprot_stb,
  input  logic           wrsr_stb,
  input  logic           modify_stb,
  input  logic           cs_release,
  input  logic           addr_complete,
  input  logic           byte_aligned,
  input  logic           hw_wp,
  input  logic [A_W-1:0] cmd_addr,
  input  logic [D_W-1:0] sr_data,
  output logic           modify_grant,
  output logic           wel,
  output logic           lock_bit,
  output logic [N_S-1:0] prot_bits,
  output logic [Q_W-1:0] qry_byte
);
  localparam int S_W = $clog2(N_S);

  logic           rst_n_s;
  logic [S_W-1:0] sect_idx;
  logic           set_one, clr_one, set_all, clr_all;
  logic           addr_unused;

  assign addr_unused = ^{cmd_addr[A_W-1:20], cmd_addr[12:0]};

  wpm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  wpm_sect_dec #(.SECT_W(S_W), .BIG_SECTS(B_S)) u_dec (
    .addr_hi(cmd_addr[19:13]), .sect_idx(sect_idx)
  );

  wpm_ctrl #(.SR_W(D_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .req_wren(wren_stb), .req_wrdi(wrdi_stb),
    .req_prot(prot_stb), .req_unprot(unprot_stb),
    .req_wrsr(wrsr_stb), .req_mod(modify_stb),
    .cs_rel(cs_release), .addr_complete(addr_complete),
    .byte_aligned(byte_aligned), .hw_wp(hw_wp), .sr_data(sr_data),
    .sect_is_prot(prot_bits[sect_idx]),
    .wel(wel), .lock(lock_bit), .grant(modify_grant),
    .bank_set_one(set_one), .bank_clr_one(clr_one),
    .bank_set_all(set_all), .bank_clr_all(clr_all)
  );

  wpm_prot_bank #(.NUM_SECT(N_S), .SECT_W(S_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s),
    .set_one(set_one), .clr_one(clr_one),
    .set_all(set_all), .clr_all(clr_all),
    .sect_idx(sect_idx), .bits(prot_bits)
  );

  assign qry_byte = {Q_W{prot_bits[sect_idx]}};

  a_r7_locked_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n_s)
    lock_bit |=> $stable(prot_bits));

  a_r2_bits_need_wel: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wel |=> $stable(prot_bits));
endmodule

// File: tb/tb_wp_sector_mgr.sv
`timescale 1ns/1ps
module tb_wp_sector_mgr;
  logic        clk, rst_n;
  logic        wren_stb, wrdi_stb, prot_stb, unprot_stb, wrsr_stb, modify_stb, cs_release;
  logic        addr_complete, byte_aligned, hw_wp;
  logic [23:0] cmd_addr;
  logic [7:0]  sr_data;
  logic        modify_grant, wel, lock_bit;
  logic [18:0] prot_bits;
  logic [7:0]  qry_byte;

  int checks = 0, errors = 0;
  logic        m_wel, m_lock, m_pend;
  logic [18:0] m_bits;

  wp_sector_mgr dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int sect_of(logic [23:0] a);
    if (a[19:16] != 4'hF) return int'(a[19:16]);
    if (a[15:14] == 2'b00) return 15;
    if (a[15:13] == 3'b010) return 16;
    if (a[15:13] == 3'b011) return 17;
    return 18;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // op: 0 idle,1 wren,2 wrdi,3 prot,4 unprot,5 wrsr,6 modify,7 cs release
  task automatic do_op(int op, logic [23:0] a, logic [7:0] d, bit full, bit algn, bit wp, string tag);
    logic exp_grant;
    int s;
    @(negedge clk);
    cmd_addr = a; sr_data = d; addr_complete = full; byte_aligned = algn; hw_wp = wp;
    wren_stb = (op == 1); wrdi_stb = (op == 2); prot_stb = (op == 3); unprot_stb = (op == 4);
    wrsr_stb = (op == 5); modify_stb = (op == 6); cs_release = (op == 7);
    s = sect_of(a);
    exp_grant = 1'b0;
    if (op == 7) begin
      if (m_pend) m_wel = 1'b0;
      m_pend = 1'b0;
    end
    case (op)
      1: m_wel = 1'b1;
      2: begin m_wel = 1'b0; m_pend = 1'b0; end
      3, 4: if (m_wel) begin
        if (!full || !algn) m_wel = 1'b0;
        else if (m_lock) m_pend = 1'b1;
        else begin m_bits[s] = (op == 3); m_wel = 1'b0; end
      end
      5: if (m_wel) begin
        m_wel = 1'b0;
        if (!m_lock) begin
          if (d[5:2] == 4'b0000) m_bits = '0;
          else if (d[5:2] == 4'b1111) m_bits = '1;
        end
        if (d[7]) m_lock = 1'b1;
        else if (!wp) m_lock = 1'b0;
      end
      6: if (m_wel) begin
        exp_grant = !m_bits[s];
        m_wel = 1'b0;
      end
      default: ;
    endcase
    @(negedge clk);
    wren_stb = 0; wrdi_stb = 0; prot_stb = 0; unprot_stb = 0;
    wrsr_stb = 0; modify_stb = 0; cs_release = 0;
    chk(tag, "wel", wel, m_wel);
    chk(tag, "lock", lock_bit, m_lock);
    chk(tag, "bits", prot_bits, m_bits);
    chk(tag, "grant", modify_grant, exp_grant);
    chk({tag, " R11"}, "qry", qry_byte, m_bits[sect_of(a)] ? 8'hFF : 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; wren_stb = 0; wrdi_stb = 0; prot_stb = 0; unprot_stb = 0;
    wrsr_stb = 0; modify_stb = 0; cs_release = 0; addr_complete = 1;
    byte_aligned = 1; hw_wp = 0; cmd_addr = '0; sr_data = '0;
    m_wel = 0; m_lock = 0; m_pend = 0; m_bits = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "wel", wel, 0);
    chk("R10", "lock", lock_bit, 0);
    chk("R10", "bits", prot_bits, 19'h7FFFF);
    chk("R10", "grant", modify_grant, 0);

    // R2: nothing happens without the latch
    do_op(4, 24'h010000, 8'h00, 1, 1, 0, "R2 unprot no wel");
    do_op(5, 24'h0, 8'h00, 1, 1, 0, "R2 wrsr no wel");
    do_op(6, 24'h000100, 8'h00, 1, 1, 0, "R2 modify no wel");
    // R4: protected sector
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(6, 24'h000100, 8'h00, 1, 1, 0, "R4 modify protected");
    // R8 global unprotect, then R5 protect 16 and 18
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(5, 24'h0, 8'h00, 1, 1, 0, "R8 global unprotect");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(3, 24'h0F4000, 8'h00, 1, 1, 0, "R5 protect 16");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(3, 24'h0F8000, 8'h00, 1, 1, 0, "R5 protect 18");
    // R1 boundaries, R12 upper bits
    do_op(0, 24'h0EFFFF, 8'h00, 1, 1, 0, "R1 sect14");
    do_op(0, 24'h0F3FFF, 8'h00, 1, 1, 0, "R1 sect15 top");
    do_op(0, 24'h0F4000, 8'h00, 1, 1, 0, "R1 sect16 base");
    do_op(0, 24'h0F5FFF, 8'h00, 1, 1, 0, "R1 sect16 top");
    do_op(0, 24'h0F6000, 8'h00, 1, 1, 0, "R1 sect17");
    do_op(0, 24'h0FFFFF, 8'h00, 1, 1, 0, "R1 sect18");
    do_op(0, 24'hAF4000, 8'h00, 1, 1, 0, "R12 upper bits");
    // R4 grant on unprotected sector, R3 auto clear
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(6, 24'h0F6000, 8'h00, 1, 1, 0, "R4 modify grant");
    do_op(0, 24'h0F6000, 8'h00, 1, 1, 0, "R4 grant one cycle");
    // R6 aborts
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(3, 24'h020000, 8'h00, 0, 1, 0, "R6 short address");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(4, 24'h0F4000, 8'h00, 1, 0, 0, "R6 misaligned");
    // R9 set lock with 0xF0, R7 locked behaviour
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(5, 24'h0, 8'hF0, 1, 1, 0, "R9 set lock");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(4, 24'h0F8000, 8'h00, 1, 1, 0, "R7 unprot locked");
    do_op(7, 24'h0F8000, 8'h00, 1, 1, 0, "R7 release clears wel");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(5, 24'h0, 8'h3C, 1, 1, 1, "R7 global blocked");
    do_op(1, 24'h0, 8'h00, 1, 1, 1, "R3 wren");
    do_op(5, 24'h0, 8'h0F, 1, 1, 1, "R9 wp keeps lock");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(5, 24'h0, 8'h0F, 1, 1, 0, "R9 clear lock");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(2, 24'h0, 8'h00, 1, 1, 0, "R3 wrdi");
    do_op(1, 24'h0, 8'h00, 1, 1, 0, "R3 wren");
    do_op(5, 24'h0, 8'h7C, 1, 1, 0, "R8 global protect");

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 900; i++) begin
      int r, op;
      logic [23:0] a;
      logic [7:0] d;
      r = int'($urandom_range(0, 10));
      case (r)
        0, 1, 2: op = 1;
        3: op = 2;
        4: op = 3;
        5: op = 4;
        6: op = 5;
        7, 8: op = 6;
        9: op = 7;
        default: op = 0;
      endcase
      a = 24'($urandom);
      if ($urandom_range(0, 1) == 1) a[19:16] = 4'hF;
      case ($urandom_range(0, 5))
        0: d = 8'h00;
        1: d = 8'h3C;
        2: d = 8'h0F;
        3: d = 8'hF0;
        4: d = 8'h80;
        default: d = 8'($urandom);
      endcase
      do_op(op, a, d, $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
            $urandom_range(0, 3) == 0, "R2-mix random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule